// File: doc/BRIEF.md
# Instruction Fetch and Decode Sequencer

This block is the control engine of a small stored-program processor with 16-bit addresses and byte-wide memory. A start pulse first reads the initial stack pointer. The word for it sits at a fixed vector address and is held high byte first. Then, starting at address zero, the block repeatedly fetches a one-byte instruction specifier and decides at once whether the instruction carries a two-byte operand. If it does, the block fetches the operand into an instruction register, advances the program counter, forms the operand's effective address and hands the instruction to an external execution unit through a valid/done handshake.

The loop ends in one of two ways. A zero specifier halts the machine cleanly. A specifier whose addressing field is not supported halts it with an error flag, and the flag keeps the offending byte. The arithmetic datapath lives elsewhere. This block only supplies the instruction, its effective address and the current program counter and stack pointer. The index register value comes in from the datapath.

Top module: `fde_sequencer`

## Requirements
- R1: After reset the block is idle: no memory request, no execute request, `halted`=0, `err`=0 and `pc`=0x0000.
- R2: A `start` pulse while idle or halted reads the byte at 0xFFF4 and then the byte at 0xFFF5, sets `sp` to {byte@FFF4, byte@FFF5}, sets `pc` to 0x0000 and then fetches the specifier at 0x0000.
- R3: A memory request keeps `mem_req` high and `mem_addr` unchanged until the cycle where `mem_ack` is high. `mem_rdata` is taken in that cycle.
- R4: A specifier below 0x12, other than 0x00, is unary. The block fetches one byte, presents `exec_ir` = {spec, 0x0000} and has `pc` advanced by 1 while executing.
- R5: A specifier of 0x12 or above is non-unary. The block reads the bytes at pc+1 and pc+2 into `exec_ir[15:8]` and `exec_ir[7:0]`, and `pc` has advanced by 3 while executing.
- R6: Specifier 0x00 halts with no execute request, `halted`=1, `err`=0 and `pc` one past the stop byte.
- R7: For a specifier of 0x40 or above, the low three bits select the addressing mode. 001 is direct, with `exec_addr` = operand word and `exec_addr_valid`=1.
- R8: Mode 011 is stack-relative: `exec_addr` = (`sp` + operand) mod 2^16.
- R9: Mode 101 is indexed: `exec_addr` = (operand + `x_val`) mod 2^16.
- R10: Mode 000 at or above 0x40, and every non-unary specifier from 0x12 to 0x3F, are immediate. These give `exec_addr_valid`=0, and so do unary instructions.
- R11: Modes 010, 100, 110 and 111, and mode 000 at or above 0xE0, are illegal. The block halts with `err`=1 and `err_spec` = the specifier, fetches no operand, issues no execute request and leaves `pc` at the specifier's address.
- R12: `exec_valid` stays high with `exec_ir` stable until `exec_done`. The next fetch then uses the advanced `pc`.
- R13: A new `start` clears `err` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution (accepted when idle or halted) |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Read completes this cycle |
| x_val | input | 16 | Current index register value |
| exec_valid | output | 1 | Instruction ready for the execution unit |
| exec_ir | output | 24 | Specifier and operand word |
| exec_addr | output | 16 | Effective operand address |
| exec_addr_valid | output | 1 | exec_addr is meaningful |
| exec_done | input | 1 | Execution unit finished |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| halted | output | 1 | Machine stopped |
| err | output | 1 | Stopped on an illegal specifier |
| err_spec | output | 8 | Specifier that caused the error |

## Verification
Every one of the 256 specifier values is run as a separate program. Each program has a stop byte behind it, and its operand word, stack pointer and index value are derived arithmetically from the specifier, so some address sums wrap past 0xFFFF. The number of memory reads and the halt address tell stop, illegal, unary and non-unary fetch lengths apart. The effective address separates direct, stack-relative, indexed and immediate forms. Memory and execute latencies of 0 to 2 cycles vary with the specifier, which exercises both hold conditions of the handshakes.

// File: rtl/fde_pkg.sv
package fde_pkg;
    localparam int unsigned AW  = 16;
    localparam int unsigned BW  = 8;
    localparam int unsigned IRW = BW + AW;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SPH, ST_SPL, ST_SPEC, ST_OPH, ST_OPL, ST_EXEC, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        AM_NONE, AM_IMM, AM_DIR, AM_STK, AM_IDX
    } amode_e;

    typedef struct packed {
        state_e           st;
        logic [AW-1:0]    pc;
        logic [AW-1:0]    sp;
        logic [IRW-1:0]   ir;
        logic [BW-1:0]    sp_hi;
        logic             err;
        logic [BW-1:0]    err_spec;
    } seq_regs_t;
endpackage

// File: rtl/fde_spec_decode.sv
module fde_spec_decode
    import fde_pkg::*;
#(
    parameter logic [BW-1:0] UNARY_LIMIT = 8'h12,
    parameter logic [BW-1:0] MODE_BASE   = 8'h40,
    parameter logic [BW-1:0] STORE_BASE  = 8'hE0
) (
    input  logic [BW-1:0] spec,
    output logic          is_stop,
    output logic          is_unary,
    output logic          illegal,
    output amode_e        mode
);
    logic [2:0] mode_bits;

    always_comb begin
        mode_bits = spec[2:0];
        is_stop   = (spec == '0);
        is_unary  = (spec < UNARY_LIMIT);
        illegal   = 1'b0;
        mode      = AM_NONE;
        if (!is_unary) begin
            if (spec < MODE_BASE) begin
                mode = AM_IMM;
            end else begin
                unique case (mode_bits)
                    3'b000: begin
                        if (spec >= STORE_BASE) illegal = 1'b1;
                        else                    mode    = AM_IMM;
                    end
                    3'b001:  mode    = AM_DIR;
                    3'b011:  mode    = AM_STK;
                    3'b101:  mode    = AM_IDX;
                    default: illegal = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/fde_addr_gen.sv
module fde_addr_gen
    import fde_pkg::*;
(
    input  amode_e        mode,
    input  logic [AW-1:0] opspec,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] x_val,
    output logic [AW-1:0] addr,
    output logic          addr_valid
);
    always_comb begin
        addr       = '0;
        addr_valid = 1'b0;
        unique case (mode)
            AM_DIR: begin addr = opspec;         addr_valid = 1'b1; end
            AM_STK: begin addr = sp + opspec;    addr_valid = 1'b1; end
            AM_IDX: begin addr = opspec + x_val; addr_valid = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
    import fde_pkg::*;
#(
    parameter logic [AW-1:0] SP_VEC      = 16'hFFF4,
    parameter logic [BW-1:0] UNARY_LIMIT = 8'h12,
    parameter logic [BW-1:0] MODE_BASE   = 8'h40,
    parameter logic [BW-1:0] STORE_BASE  = 8'hE0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           mem_req,
    output logic [15:0]    mem_addr,
    input  logic [7:0]     mem_rdata,
    input  logic           mem_ack,
    input  logic [15:0]    x_val,
    output logic           exec_valid,
    output logic [23:0]    exec_ir,
    output logic [15:0]    exec_addr,
    output logic           exec_addr_valid,
    input  logic           exec_done,
    output logic [15:0]    pc,
    output logic [15:0]    sp,
    output logic           halted,
    output logic           err,
    output logic [7:0]     err_spec
);
    localparam logic [AW-1:0] SP_VEC_LO = SP_VEC + AW'(1);
    localparam logic [AW-1:0] STEP_ONE  = AW'(1);
    localparam logic [AW-1:0] STEP_TWO  = AW'(2);
    localparam logic [AW-1:0] STEP_FULL = AW'(3);

    seq_regs_t r_q, r_d;

    logic [BW-1:0] dec_in;
    logic          dec_stop, dec_unary, dec_illegal;
    amode_e        dec_mode;

    // During specifier fetch the incoming byte is decoded directly; otherwise the held one.
    assign dec_in = (r_q.st == ST_SPEC) ? mem_rdata : r_q.ir[IRW-1 -: BW];

    fde_spec_decode #(
        .UNARY_LIMIT (UNARY_LIMIT),
        .MODE_BASE   (MODE_BASE),
        .STORE_BASE  (STORE_BASE)
    ) i_dec (
        .spec     (dec_in),
        .is_stop  (dec_stop),
        .is_unary (dec_unary),
        .illegal  (dec_illegal),
        .mode     (dec_mode)
    );

    fde_addr_gen i_agen (
        .mode       (dec_mode),
        .opspec     (r_q.ir[AW-1:0]),
        .sp         (r_q.sp),
        .x_val      (x_val),
        .addr       (exec_addr),
        .addr_valid (exec_addr_valid)
    );

    always_comb begin
        r_d      = r_q;
        mem_req  = 1'b0;
        mem_addr = r_q.pc;
        unique case (r_q.st)
            ST_IDLE, ST_HALT: begin
                if (start) begin
                    r_d.st       = ST_SPH;
                    r_d.pc       = '0;
                    r_d.err      = 1'b0;
                    r_d.err_spec = '0;
                end
            end
            ST_SPH: begin
                mem_req  = 1'b1;
                mem_addr = SP_VEC;
                if (mem_ack) begin
                    r_d.sp_hi = mem_rdata;
                    r_d.st    = ST_SPL;
                end
            end
            ST_SPL: begin
                mem_req  = 1'b1;
                mem_addr = SP_VEC_LO;
                if (mem_ack) begin
                    r_d.sp = {r_q.sp_hi, mem_rdata};
                    r_d.st = ST_SPEC;
                end
            end
            ST_SPEC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.pc;
                if (mem_ack) begin
                    r_d.ir = {mem_rdata, {AW{1'b0}}};
                    if (dec_illegal) begin
                        r_d.err      = 1'b1;
                        r_d.err_spec = mem_rdata;
                        r_d.st       = ST_HALT;
                    end else if (dec_stop) begin
                        r_d.pc = r_q.pc + STEP_ONE;
                        r_d.st = ST_HALT;
                    end else if (dec_unary) begin
                        r_d.pc = r_q.pc + STEP_ONE;
                        r_d.st = ST_EXEC;
                    end else begin
                        r_d.st = ST_OPH;
                    end
                end
            end
            ST_OPH: begin
                mem_req  = 1'b1;
                mem_addr = r_q.pc + STEP_ONE;
                if (mem_ack) begin
                    r_d.ir[AW-1 -: BW] = mem_rdata;
                    r_d.st             = ST_OPL;
                end
            end
            ST_OPL: begin
                mem_req  = 1'b1;
                mem_addr = r_q.pc + STEP_TWO;
                if (mem_ack) begin
                    r_d.ir[BW-1:0] = mem_rdata;
                    r_d.pc         = r_q.pc + STEP_FULL;
                    r_d.st         = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (exec_done) r_d.st = ST_SPEC;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pc: '0, sp: '0, ir: '0, sp_hi: '0, err: 1'b0, err_spec: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign exec_valid = (r_q.st == ST_EXEC);
    assign exec_ir    = r_q.ir;
    assign pc         = r_q.pc;
    assign sp         = r_q.sp;
    assign halted     = (r_q.st == ST_HALT);
    assign err        = r_q.err;
    assign err_spec   = r_q.err_spec;
endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk #(
    parameter logic [15:0] VEC = 16'hFFF4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ack,
    input logic        exec_valid,
    input logic        exec_done,
    input logic [23:0] exec_ir,
    input logic        halted,
    input logic        err
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_exec_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && !exec_done |=> exec_valid && $stable(exec_ir));

    p_err_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> halted);

    p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req && !exec_valid);

    p_one_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && exec_valid));

    p_start_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mem_req && !exec_valid |=> mem_req && (mem_addr == VEC));

    p_start_clr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        start && halted |=> !err);
endmodule

bind fde_sequencer fde_sequencer_chk #(.VEC(SP_VEC)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .exec_valid (exec_valid),
    .exec_done  (exec_done),
    .exec_ir    (exec_ir),
    .halted     (halted),
    .err        (err)
);

// File: tb/test_fde_sequencer.sv
`timescale 1ns/1ps
module test_fde_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ack = 1'b0;
    logic [15:0] x_val = 16'h0000;
    logic        exec_valid;
    logic [23:0] exec_ir;
    logic [15:0] exec_addr;
    logic        exec_addr_valid;
    logic        exec_done = 1'b0;
    logic [15:0] pc, sp;
    logic        halted, err;
    logic [7:0]  err_spec;

    logic [7:0]  mem [0:65535];
    int          checks = 0;
    int          errors = 0;
    int          lat = 0;
    int          reads = 0;
    int          execs = 0;
    int          hold_err = 0;
    logic [23:0] cap_ir;
    logic [15:0] cap_addr, cap_pc;
    logic        cap_av;

    always #4 clk = ~clk;

    fde_sequencer i_fde_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .x_val(x_val), .exec_valid(exec_valid), .exec_ir(exec_ir), .exec_addr(exec_addr),
        .exec_addr_valid(exec_addr_valid), .exec_done(exec_done),
        .pc(pc), .sp(sp), .halted(halted), .err(err), .err_spec(err_spec)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory responder with programmable latency.
    initial begin
        int cnt = 0;
        logic [15:0] held = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt == 0) held = mem_addr;
                else if (mem_addr != held) hold_err++;
                if (cnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr];
                    reads++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Execution-unit responder with the same latency.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (exec_done) begin
                exec_done = 1'b0;
                cnt = 0;
            end else if (exec_valid) begin
                if (cnt == 0) begin
                    cap_ir = exec_ir; cap_addr = exec_addr; cap_av = exec_addr_valid; cap_pc = pc;
                end else if (exec_ir != cap_ir) begin
                    hold_err++;
                end
                if (cnt >= lat) begin
                    exec_done = 1'b1;
                    execs++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !exec_valid, "R1 idle", {mem_req, exec_valid}, 0);
        chk(!halted && !err, "R1 flags", {halted, err}, 0);
        chk(pc == 16'h0, "R1 pc", pc, 0);

        for (int s = 0; s < 256; s++) begin
            logic [7:0]  spec;
            logic [15:0] opv, spv, xv, exp_addr, exp_pc;
            logic [2:0]  m;
            int          kind, exp_reads, wait_cyc;
            bit          exp_av;
            spec = 8'(s);
            lat  = s % 3;
            opv  = {spec ^ 8'h5A, ~spec};
            spv  = 16'hF000 + 16'(s) * 16'h0123;
            xv   = 16'(s) * 16'h0301 + 16'h8000;
            x_val = xv;
            m = spec[2:0];
            // kind: 0 stop, 1 illegal, 2 unary, 3 non-unary
            if (spec == 8'h00) kind = 0;
            else if (spec < 8'h12) kind = 2;
            else if (spec >= 8'h40 && (m == 3'b010 || m == 3'b100 || m == 3'b110 || m == 3'b111)) kind = 1;
            else if (spec >= 8'hE0 && m == 3'b000) kind = 1;
            else kind = 3;
            exp_av = 1'b0; exp_addr = 16'h0;
            if (kind == 3 && spec >= 8'h40) begin
                if (m == 3'b001) begin exp_av = 1'b1; exp_addr = opv; end
                if (m == 3'b011) begin exp_av = 1'b1; exp_addr = spv + opv; end
                if (m == 3'b101) begin exp_av = 1'b1; exp_addr = opv + xv; end
            end
            case (kind)
                0: begin exp_reads = 3; exp_pc = 16'h1; end
                1: begin exp_reads = 3; exp_pc = 16'h0; end
                2: begin exp_reads = 4; exp_pc = 16'h2; end
                default: begin exp_reads = 6; exp_pc = 16'h4; end
            endcase

            mem[16'h0000] = spec;
            if (kind == 2) begin
                mem[16'h0001] = 8'h00;
            end else begin
                mem[16'h0001] = opv[15:8];
                mem[16'h0002] = opv[7:0];
                mem[16'h0003] = 8'h00;
            end
            mem[16'hFFF4] = spv[15:8];
            mem[16'hFFF5] = spv[7:0];
            reads = 0; execs = 0; hold_err = 0;

            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (s == 0 || kind == 1 || (s % 37) == 0) begin
                chk(!err, "R13 err cleared", err, 0);
                chk(mem_req && mem_addr == 16'hFFF4, "R2 vector read", mem_addr, 16'hFFF4);
            end
            wait_cyc = 0;
            while (!halted && wait_cyc < 200) begin
                @(negedge clk);
                wait_cyc++;
            end
            chk(halted, "R6 halted", halted, 1);
            chk(sp == spv, "R2 sp", sp, spv);
            chk(reads == exp_reads, "R5 fetch length", reads, exp_reads);
            chk(pc == exp_pc, "R4 halt pc", pc, exp_pc);
            chk(hold_err == 0, "R3 R12 hold", hold_err, 0);
            if (kind == 1) begin
                chk(err && err_spec == spec, "R11 illegal", {err, err_spec}, {1'b1, spec});
                chk(execs == 0, "R11 no exec", execs, 0);
            end else begin
                chk(!err, "R6 no err", err, 0);
            end
            if (kind == 0) chk(execs == 0, "R6 stop no exec", execs, 0);
            if (kind == 2) begin
                chk(execs == 1 && cap_ir == {spec, 16'h0}, "R4 unary ir", cap_ir, {spec, 16'h0});
                chk(cap_pc == 16'h1, "R4 pc+1", cap_pc, 1);
                chk(!cap_av, "R10 unary addr", cap_av, 0);
            end
            if (kind == 3) begin
                chk(execs == 1 && cap_ir == {spec, opv}, "R5 operand ir", cap_ir, {spec, opv});
                chk(cap_pc == 16'h3, "R12 pc+3", cap_pc, 3);
                chk(cap_av == exp_av, "R10 addr valid", cap_av, exp_av);
                if (exp_av) begin
                    if (m == 3'b001) chk(cap_addr == exp_addr, "R7 direct", cap_addr, exp_addr);
                    if (m == 3'b011) chk(cap_addr == exp_addr, "R8 stack", cap_addr, exp_addr);
                    if (m == 3'b101) chk(cap_addr == exp_addr, "R9 indexed", cap_addr, exp_addr);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule